// File: doc/BRIEF.md
# Cascadable Programmable Down Counter

This block is a four-bit natural-binary down counter for frequency division. Two count inputs of opposite sense steer it. A rising edge on the first input counts while the second input is low. A falling edge on the second input counts while the first input is high. A level-sensitive load copies four preset bits into the register. An asynchronous master reset clears the register and wins over every other input.

The decoded terminal-count output is high when the register is zero and the cascade input is high, and only while load is not asserted. In a single stage the terminal count drives the load pin, so the stage reloads its preset after reaching zero and divides the count-edge rate by the preset value. Stages chain through the cascade input with no extra gates.

The block runs on one free-running system clock. Both count inputs are synchronized and edge-detected on that clock, so at most one decrement happens per system clock.

Top module: `pdown_counter`

## Requirements
- R1: The count register is four bits wide and steps down by exactly one per accepted count event. A decrement from 0 gives 15.
- R2: While loadLvl is high, the register takes the value of preset at every system clock edge, including when preset changes. Count edges have no effect while loadLvl is high.
- R3: When loadLvl and tickFall are low, a rising edge on tickRise decrements the register. The new value appears at the third rising system-clock edge after the input changes, and not before. A falling edge on tickRise never counts.
- R4: When loadLvl is low and tickRise is high, a falling edge on tickFall decrements the register. This has the same three-clock latency as R3.
- R5: A rising edge on tickRise while tickFall is high does not change the register. A falling edge on tickFall while tickRise is low does not change it either. A rising edge on tickFall never changes it.
- R6: termOut is high exactly when the register is zero, cascadeIn is high, and loadLvl was low at the previous system-clock edge. termOut is low for any nonzero count.
- R7: While masterRst is high, the register reads 0 at once, without waiting for a clock edge. This holds whatever the load, preset and count inputs do.
- R8: With termOut wired to loadLvl, cascadeIn high and a preset n from 1 to 15, termOut rises once every n count edges. After 3n count edges the register again holds n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| masterRst | input | 1 | Asynchronous active-high clear of the count register |
| loadLvl | input | 1 | Level-sensitive parallel load, active high |
| preset | input | 4 | Value copied into the register during load |
| tickRise | input | 1 | Count input that acts on its rising edge, enabled while tickFall is low |
| tickFall | input | 1 | Count input that acts on its falling edge, enabled while tickRise is high |
| cascadeIn | input | 1 | Cascade qualifier for the terminal count |
| countOut | output | 4 | Current count value |
| termOut | output | 1 | Decoded terminal count |

## Verification
A change on a count input passes through two synchronizer flops, then edge detection, then the count register. Its effect is therefore due at the third system-clock edge. The latency check samples at the falling clock edge after the second rising edge, to confirm no change yet, and again after the third. A load is seen one edge after it is applied. The terminal count falls one edge after load rises, because it is qualified by the registered load. Reset takes effect without a clock, so it is sampled a moment after being raised. All other checks wait several clocks after each stimulus, which keeps them clear of the pipeline, and sample on falling edges away from the active edge.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
  // Strobes from control to datapath, valid for one system clock
  typedef struct packed {
    logic load;  // copy preset into the register
    logic dec;   // step the register down by one
  } ctrlStrobes_t;
endpackage

// File: rtl/pdc_ctrl.sv
module pdc_ctrl
  import pdc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         masterRst,
  input  logic         tickRise,
  input  logic         tickFall,
  input  logic         loadLvl,
  output ctrlStrobes_t strobes,
  output logic         loadSeen
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] chainA, chainB;
  logic syncA, syncB, prevA, prevB;
  logic riseA, fallB, countEvent;

  // Synchronizer chains, one flop per stage
  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : gSync
      if (g == 0) begin : gFirst
        always_ff @(posedge clk or posedge masterRst) begin
          if (masterRst) begin
            chainA[0] <= 1'b0;
            chainB[0] <= 1'b0;
          end else begin
            chainA[0] <= tickRise;
            chainB[0] <= tickFall;
          end
        end
      end else begin : gNext
        always_ff @(posedge clk or posedge masterRst) begin
          if (masterRst) begin
            chainA[g] <= 1'b0;
            chainB[g] <= 1'b0;
          end else begin
            chainA[g] <= chainA[g-1];
            chainB[g] <= chainB[g-1];
          end
        end
      end
    end
  endgenerate

  assign syncA = chainA[LAST];
  assign syncB = chainB[LAST];

  // Previous synchronized samples for edge detection, plus the registered load
  always_ff @(posedge clk or posedge masterRst) begin
    if (masterRst) begin
      prevA    <= 1'b0;
      prevB    <= 1'b0;
      loadSeen <= 1'b0;
    end else begin
      prevA    <= syncA;
      prevB    <= syncB;
      loadSeen <= loadLvl;
    end
  end

  assign riseA = syncA & ~prevA;
  assign fallB = ~syncB & prevB;

  // Each input is enabled by the level of the other; the two edges merge into one event
  assign countEvent = (riseA & ~syncB) | (fallB & syncA);

  always_comb begin
    strobes.load = loadLvl;
    strobes.dec  = countEvent & ~loadLvl;
  end

  // R2: no decrement is requested while load is asserted
  p_no_dec_in_load_r2 : assert property (@(posedge clk) disable iff (masterRst)
    strobes.dec |-> !loadLvl);

  // R5: a decrement needs a change on one of the synchronized inputs
  p_dec_needs_edge_r5 : assert property (@(posedge clk) disable iff (masterRst)
    strobes.dec |-> ((syncA != prevA) || (syncB != prevB)));

  // R5: a rising edge on the first input while the second is high gives no decrement
  p_rise_gated_r5 : assert property (@(posedge clk) disable iff (masterRst)
    (riseA && syncB && !fallB) |-> !strobes.dec);
endmodule

// File: rtl/pdc_dpath.sv
module pdc_dpath
  import pdc_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             masterRst,
  input  ctrlStrobes_t     strobes,
  input  logic [WIDTH-1:0] preset,
  input  logic             cascadeIn,
  input  logic             loadSeen,
  output logic [WIDTH-1:0] countOut,
  output logic             termOut
);
  localparam logic [WIDTH-1:0] ZERO = '0;
  localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);

  logic [WIDTH-1:0] countQ;

  // Load beats decrement; reset beats both
  always_ff @(posedge clk or posedge masterRst) begin
    if (masterRst)
      countQ <= ZERO;
    else if (strobes.load)
      countQ <= preset;
    else if (strobes.dec)
      countQ <= countQ - ONE;
  end

  assign countOut = countQ;
  assign termOut  = (countQ == ZERO) & cascadeIn & ~loadSeen;

  // R2: load copies the preset at the next edge
  p_load_copy_r2 : assert property (@(posedge clk) disable iff (masterRst)
    strobes.load |=> (countQ == $past(preset)));

  // R1: one decrement step, with wrap from zero
  p_step_down_r1 : assert property (@(posedge clk) disable iff (masterRst)
    (strobes.dec && !strobes.load) |=> (countQ == $past(countQ) - ONE));

  // R5: no strobe means the count holds
  p_hold_r5 : assert property (@(posedge clk) disable iff (masterRst)
    (!strobes.dec && !strobes.load) |=> $stable(countQ));

  // R6: terminal count only at zero with the cascade input high
  p_tc_zero_r6 : assert property (@(posedge clk) disable iff (masterRst)
    termOut |-> ((countOut == ZERO) && cascadeIn));

  // R7: reset holds the count at zero
  p_reset_clear_r7 : assert property (@(posedge clk)
    masterRst |-> (countOut == ZERO));
endmodule

// File: rtl/pdown_counter.sv
module pdown_counter
  import pdc_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             masterRst,
  input  logic             loadLvl,
  input  logic [WIDTH-1:0] preset,
  input  logic             tickRise,
  input  logic             tickFall,
  input  logic             cascadeIn,
  output logic [WIDTH-1:0] countOut,
  output logic             termOut
);
  ctrlStrobes_t strobes;
  logic         loadSeen;

  pdc_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk      (clk),
    .masterRst(masterRst),
    .tickRise (tickRise),
    .tickFall (tickFall),
    .loadLvl  (loadLvl),
    .strobes  (strobes),
    .loadSeen (loadSeen)
  );

  pdc_dpath #(.WIDTH(WIDTH)) uDpath (
    .clk      (clk),
    .masterRst(masterRst),
    .strobes  (strobes),
    .preset   (preset),
    .cascadeIn(cascadeIn),
    .loadSeen (loadSeen),
    .countOut (countOut),
    .termOut  (termOut)
  );
endmodule

// File: tb/sim_pdown_counter.sv
`timescale 1ns/1ps
module sim_pdown_counter;
  logic       clk = 1'b0;
  logic       masterRst = 1'b1;
  logic       loadDrv = 1'b0;
  logic       tcMode = 1'b0;
  logic [3:0] preset = 4'd0;
  logic       tickRise = 1'b0;
  logic       tickFall = 1'b0;
  logic       cascadeIn = 1'b1;
  logic [3:0] countOut;
  logic       termOut;
  logic       loadLvl;

  int checks = 0;
  int errors = 0;
  int tcRises = 0;
  logic monOn = 1'b0;
  logic tcPrev = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  assign loadLvl = tcMode ? termOut : loadDrv;

  pdown_counter u0 (
    .clk(clk), .masterRst(masterRst), .loadLvl(loadLvl), .preset(preset),
    .tickRise(tickRise), .tickFall(tickFall), .cascadeIn(cascadeIn),
    .countOut(countOut), .termOut(termOut)
  );

  always @(negedge clk) begin
    if (monOn && termOut && !tcPrev) tcRises++;
    tcPrev = termOut;
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clocks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseRise();
    tickRise = 1'b1; clocks(6);
    tickRise = 1'b0; clocks(6);
  endtask

  task automatic loadValue(input logic [3:0] v);
    loadDrv = 1'b1; preset = v; clocks(1);
    loadDrv = 1'b0; clocks(2);
  endtask

  task automatic testReset();
    clocks(1);
    check("R7 reset state", countOut, 0);
    masterRst = 1'b0; clocks(2);
  endtask

  task automatic testLoad();
    loadDrv = 1'b1; preset = 4'd9; clocks(1);
    check("R2 load value", countOut, 9);
    preset = 4'd5; clocks(1);
    check("R2 load follows preset", countOut, 5);
    pulseRise();
    check("R2 edge ignored during load", countOut, 5);
    loadDrv = 1'b0; clocks(2);
  endtask

  task automatic testRise();
    tickRise = 1'b1; clocks(2);
    check("R3 no change after two edges", countOut, 5);
    clocks(1);
    check("R3 decrement at third edge", countOut, 4);
    clocks(3);
    tickRise = 1'b0; clocks(5);
    check("R3 falling edge of tickRise ignored", countOut, 4);
    pulseRise();
    check("R3 second rising edge", countOut, 3);
  endtask

  task automatic testFall();
    tickFall = 1'b1; clocks(5);
    check("R5 rising tickFall ignored", countOut, 3);
    tickRise = 1'b1; clocks(5);
    check("R5 tickRise gated by tickFall high", countOut, 3);
    tickFall = 1'b0; clocks(2);
    check("R4 no change after two edges", countOut, 3);
    clocks(1);
    check("R4 falling tickFall counts", countOut, 2);
    tickFall = 1'b1; clocks(5);
    tickRise = 1'b0; clocks(5);
    tickFall = 1'b0; clocks(5);
    check("R5 tickFall gated by tickRise low", countOut, 2);
  endtask

  task automatic testTermWrap();
    loadValue(4'd0);
    cascadeIn = 1'b1; clocks(1);
    check("R6 terminal count at zero", termOut, 1);
    cascadeIn = 1'b0; #1;
    check("R6 cascade low masks terminal count", termOut, 0);
    cascadeIn = 1'b1;
    loadDrv = 1'b1; clocks(1);
    check("R6 load masks terminal count", termOut, 0);
    loadDrv = 1'b0; clocks(2);
    pulseRise();
    check("R1 wrap from zero", countOut, 15);
    check("R6 nonzero count gives no terminal count", termOut, 0);
    pulseRise();
    check("R1 step below wrap", countOut, 14);
  endtask

  task automatic testResetPriority();
    loadDrv = 1'b1; preset = 4'd7; clocks(1);
    masterRst = 1'b1; #1;
    check("R7 reset without clock", countOut, 0);
    clocks(2);
    check("R7 reset beats load", countOut, 0);
    loadDrv = 1'b0;
    pulseRise();
    check("R7 reset beats counting", countOut, 0);
    masterRst = 1'b0; clocks(2);
  endtask

  task automatic testDivide();
    for (int n = 1; n <= 15; n++) begin
      masterRst = 1'b1; tcMode = 1'b1; cascadeIn = 1'b1;
      preset = 4'(n); tickRise = 1'b0; tickFall = 1'b0;
      clocks(2);
      masterRst = 1'b0; clocks(3);
      tcRises = 0; monOn = 1'b1;
      for (int k = 0; k < 3 * n; k++) pulseRise();
      monOn = 1'b0;
      check($sformatf("R8 terminal count rises for preset %0d", n), tcRises, 3);
      check($sformatf("R8 reloaded value for preset %0d", n), countOut, n);
    end
    tcMode = 1'b0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    summary();
    $finish;
  end

  initial begin
    testReset();
    testLoad();
    testRise();
    testFall();
    testTermWrap();
    testResetPriority();
    testDivide();
    summary();
    $finish;
  end
endmodule